// File: doc/BRIEF.md
# Field-Sequential RGB LED Brightness Controller

This block drives the brightness of a multi-channel RGB LED display that shows one colour at a time. Time is cut into three fixed colour fields: red, then green, then blue, then red again. Each field lasts about 3 ms, so a full colour cycle takes about 9 ms, inside the 10 ms that persistence of vision needs to blend the colours. A prescaler on the system clock paces one shared 8-bit PWM counter. Every field holds a whole number of PWM periods. Each channel output is high while that counter is below the channel's 8-bit duty value for the colour being shown.

A host microcontroller loads duty values through a plain write strobe. Each write names a channel, a colour and a value. Writes land in a shadow copy. The shadow copy moves into the working copy only when a field ends, so a field that is in progress never changes brightness part way through. The current colour is output on `field_sel`, so external common-anode or column drivers can switch with the fields. The defaults give 24 channels (the parameter allows up to 32) and a field of 122 × 256 × 12 system clocks, which is about 3 ms at 125 MHz.

Top module: `rgb_field_pwm`

## Requirements
- R1: While reset is asserted, and at its release, every `pwm_out` bit is 0, `field_sel` is 0 (red), and all stored duty values are 0.
- R2: `field_sel` codes are 0 for red, 1 for green and 2 for blue. It steps 0→1→2→0 and never shows 3.
- R3: Every field lasts exactly TICK_DIV·256·PWM_PER_FIELD clock cycles. A field change happens only where the shared PWM count returns to 0, so no PWM period straddles a field boundary.
- R4: A channel's output is high exactly while the shared PWM count is below that channel's working duty value for the active colour.
- R5: A working duty of 0 keeps the output low for the whole field.
- R6: A working duty of 255 keeps the output high for counts 0 to 254. Every output is low at count 255.
- R7: A write goes to the shadow copy. All shadow values become working values at the next field boundary and never earlier. A write sampled on the boundary clock edge itself waits for the boundary after that one.
- R8: A write is ignored if its channel index is NUM_CH or above, or if its colour code is 3 (valid codes: 0 red, 1 green, 2 blue).
- R9: Outputs rise only at PWM count 0, so all channels start their pulses together, in phase with the field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Duty write strobe, sampled on the rising clock edge |
| wr_chan | input | $clog2(NUM_CH) | Channel index of the write |
| wr_color | input | 2 | Colour of the write: 0 red, 1 green, 2 blue |
| wr_duty | input | DUTY_W | Duty value to store |
| pwm_out | output | NUM_CH | One PWM output per channel |
| field_sel | output | 2 | Active colour field: 0 red, 1 green, 2 blue |

## Verification
A write sampled on a clock edge lands in the shadow copy at once. It first shows on `pwm_out` only in the cycle after the next field-boundary edge. The PWM count and `field_sel` move on the edge that makes them due, and `pwm_out` follows them combinationally in that same cycle. The bench model keeps the count of clock edges since reset. From that count it computes the field, the PWM count and the moment of each shadow-to-working copy. The model advances on the same edge as the design, and the outputs are compared at the falling edge that follows, so every result is checked in the exact cycle it becomes due. Directed checks wait for chosen (field, count) positions to hit the duty extremes, a mid-field write, a write on the boundary edge and the ignored writes.

// File: rtl/rgb_field_pwm.sv
module rgb_field_pwm #(
  parameter int NUM_CH        = 24,
  parameter int DUTY_W        = 8,
  parameter int TICK_DIV      = 122,
  parameter int PWM_PER_FIELD = 12,
  localparam int CH_AW        = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_AW-1:0]  wr_chan,
  input  logic [1:0]        wr_color,
  input  logic [DUTY_W-1:0] wr_duty,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [1:0]        field_sel
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CYC_W = (PWM_PER_FIELD > 1) ? $clog2(PWM_PER_FIELD) : 1;
  localparam int NCOL  = 3;

  logic [PRE_W-1:0]  pre_cnt;
  logic [DUTY_W-1:0] pwm_cnt;
  logic [CYC_W-1:0]  cyc_cnt;
  logic [1:0]        field;

  logic [DUTY_W-1:0] shadow [NCOL][NUM_CH];
  logic [DUTY_W-1:0] active [NCOL][NUM_CH];

  wire tick      = pre_cnt == PRE_W'(TICK_DIV - 1);
  wire wrap      = tick && (&pwm_cnt);
  wire field_end = wrap && cyc_cnt == CYC_W'(PWM_PER_FIELD - 1);
  wire wr_ok     = wr_en && wr_color != 2'd3 &&
                   ({1'b0, wr_chan} < (CH_AW + 1)'(NUM_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pwm_cnt <= '0;
      cyc_cnt <= '0;
      field   <= 2'd0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) pwm_cnt <= pwm_cnt + 1'b1;
      if (wrap) cyc_cnt <= field_end ? '0 : cyc_cnt + 1'b1;
      if (field_end) field <= (field == 2'd2) ? 2'd0 : field + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++)
        for (int i = 0; i < NUM_CH; i++) begin
          shadow[c][i] <= '0;
          active[c][i] <= '0;
        end
    end else begin
      if (wr_ok) shadow[wr_color][wr_chan] <= wr_duty;
      if (field_end) active <= shadow;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign pwm_out[g] = pwm_cnt < active[field][g];
  end

  assign field_sel = field;
endmodule

module rgb_field_pwm_chk #(
  parameter int NUM_CH        = 24,
  parameter int DUTY_W        = 8,
  parameter int TICK_DIV      = 122,
  parameter int PWM_PER_FIELD = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        field_sel,
  input logic [DUTY_W-1:0] pwm_cnt,
  input logic [NUM_CH-1:0] pwm_out
);
  localparam logic [31:0] FIELD_CLKS = 32'(TICK_DIV * (2 ** DUTY_W) * PWM_PER_FIELD);

  logic [1:0]        prev_field;
  logic [NUM_CH-1:0] prev_out;
  logic [31:0]       since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_field <= 2'd0;
      prev_out   <= '0;
      since      <= '0;
    end else begin
      prev_field <= field_sel;
      prev_out   <= pwm_out;
      since      <= (field_sel != prev_field) ? 32'd1 : since + 32'd1;
    end
  end

  assert_field_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_sel != 2'd3);
  assert_field_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_sel != prev_field |-> field_sel == ((prev_field == 2'd2) ? 2'd0 : prev_field + 2'd1));
  assert_field_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    field_sel != prev_field |-> since == FIELD_CLKS);
  assert_boundary_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    field_sel != prev_field |-> pwm_cnt == '0);
  assert_top_count_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&pwm_cnt) |-> pwm_out == '0);
  assert_rise_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~prev_out) != '0 |-> pwm_cnt == '0);
endmodule

bind rgb_field_pwm rgb_field_pwm_chk #(
  .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .TICK_DIV(TICK_DIV), .PWM_PER_FIELD(PWM_PER_FIELD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .field_sel(field_sel), .pwm_cnt(pwm_cnt), .pwm_out(pwm_out)
);

// File: tb/rgb_field_pwm_bench.sv
module rgb_field_pwm_bench;
  localparam int NUM_CH = 24;
  localparam int AW     = $clog2(NUM_CH);
  localparam int TD     = 3;
  localparam int PPF    = 2;
  localparam int FC     = TD * 256 * PPF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_chan = '0;
  logic [1:0]        wr_color = 2'd0;
  logic [7:0]        wr_duty = 8'd0;
  logic [NUM_CH-1:0] pwm_out;
  logic [1:0]        field_sel;

  int vectors = 0;
  int misses  = 0;
  bit checking = 1'b0;

  always #4 clk = ~clk;

  rgb_field_pwm #(.NUM_CH(NUM_CH), .DUTY_W(8), .TICK_DIV(TD), .PWM_PER_FIELD(PPF)) u_rgb_field_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_color(wr_color),
    .wr_duty(wr_duty), .pwm_out(pwm_out), .field_sel(field_sel)
  );

  // behavioural reference: position derived from edges since reset
  int m_shadow [3][NUM_CH];
  int m_active [3][NUM_CH];
  longint t = 0;
  int m_pos = 0, m_field = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; m_pos = 0; m_field = 0; m_cnt = 0;
      for (int c = 0; c < 3; c++)
        for (int i = 0; i < NUM_CH; i++) begin
          m_shadow[c][i] = 0; m_active[c][i] = 0;
        end
    end else begin
      t = t + 1;
      m_pos = int'(t % (3 * FC));
      if (m_pos % FC == 0) m_active = m_shadow;
      if (wr_en && wr_color < 3 && int'(wr_chan) < NUM_CH)
        m_shadow[wr_color][wr_chan] = int'(wr_duty);
      m_field = m_pos / FC;
      m_cnt   = ((m_pos % FC) / TD) % 256;
    end
  end

  function automatic logic [NUM_CH-1:0] exp_vec();
    logic [NUM_CH-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i] = m_cnt < m_active[m_field][i];
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d field=%0d cnt=%0d)", tag, act, exp, t, m_field, m_cnt);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      logic [NUM_CH-1:0] ev;
      string tag;
      ev = exp_vec();
      chk(32'(field_sel), 32'(m_field), "R2 R3 field_sel");
      tag = "R4 pwm_out";
      for (int i = 0; i < NUM_CH; i++)
        if (pwm_out[i] !== ev[i]) begin
          if (m_active[m_field][i] == 0) tag = "R5 pwm_out";
          else if (m_active[m_field][i] == 255) tag = "R6 pwm_out";
          else if (m_cnt == 0) tag = "R9 pwm_out";
        end
      chk(32'(pwm_out), 32'(ev), tag);
    end
  end

  task automatic wr(input int ch, input int col, input int d);
    wr_en = 1'b1; wr_chan = AW'(ch); wr_color = 2'(col); wr_duty = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_at(input int f, input int c);
    do @(negedge clk); while (!(m_field == f && m_cnt == c));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(32'(pwm_out), 32'd0, "R1 reset outputs");
    chk(32'(field_sel), 32'd0, "R1 reset field");
    rst_n = 1'b1;
    checking = 1'b1;
    @(negedge clk);
    chk(32'(pwm_out), 32'd0, "R1 after release");

    for (int i = 0; i < NUM_CH; i++) begin
      wr(i, 0, i * 11);
      wr(i, 1, 255 - i * 10);
      wr(i, 2, (i == 0) ? 0 : (i == 1) ? 255 : i * 7);
    end
    wait_at(0, 200);
    chk(32'(pwm_out), 32'd0, "R7 shadow not yet active");
    wait_at(1, 5);
    chk(32'(pwm_out[3]), 32'd1, "R7 green active after boundary");
    chk(32'(pwm_out), 32'(exp_vec()), "R4 green mix");
    wait_at(1, 50);
    wr(3, 1, 0);
    wait_at(1, 60);
    chk(32'(pwm_out[3]), 32'd1, "R7 mid-field write held back");
    wait_at(2, 128);
    chk(32'(pwm_out[0]), 32'd0, "R5 zero duty low");
    wait_at(2, 254);
    chk(32'(pwm_out[1]), 32'd1, "R6 full duty high at 254");
    wait_at(2, 255);
    chk(32'(pwm_out), 32'd0, "R6 all low at 255");
    wr(25, 0, 255);
    wr(0, 3, 255);
    do @(negedge clk); while (!(m_field == 2 && m_pos % FC == FC - 1));
    wr(5, 0, 250);
    wait_at(0, 3);
    chk(32'(pwm_out[0]), 32'd0, "R8 ignored writes");
    wait_at(0, 100);
    chk(32'(pwm_out[5]), 32'd0, "R7 boundary write deferred");
    wait_at(0, 0);
    chk(32'(pwm_out), 32'(exp_vec()), "R9 common rise at count 0");
    wait_at(1, 60);
    chk(32'(pwm_out[3]), 32'd0, "R7 mid-field write applied");
    wait_at(0, 100);
    chk(32'(pwm_out[5]), 32'd1, "R7 boundary write applied");
    repeat (3 * FC) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule